// File: doc/BRIEF.md
# Check-Bit Protected Word Store with Sub-Word Merge

This block is a single-port array of 32-bit words, each held together with seven check bits in one 39-bit codeword. The check code corrects any single flipped bit and detects any two flipped bits. Requests enter through a valid/ready handshake and carry a write flag, an address, four byte enables and write data.

A store with all four enables set is encoded at once and written in the cycle it is accepted. The array cannot update part of a codeword. A byte or halfword store is therefore accepted in one cycle, which reads the stored codeword. In a second cycle the block corrects that word, splices the new lanes in, re-encodes the result and writes all 39 bits back. Ready is low during that second cycle, so any request behind it waits.

A load reads the codeword and returns the corrected word one cycle after acceptance, together with a copy masked to the requested lanes. A word load and a sub-word load take the same time. Two flags report corrected and uncorrectable errors. A per-request flip mask is XORed into the codeword as it is written, so that stored errors can be produced through the normal interface.

The controller has two states. ST_IDLE accepts requests and returns to itself on loads, full-word stores and empty stores. It takes the transition "partial accept" to ST_MERGE when a sub-word store is accepted. ST_MERGE always takes the transition "merge done" back to ST_IDLE after one cycle. It writes the merged codeword unless the read word held an uncorrectable error.

Top module: `ecc_word_mem`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, err_single and err_double are 0.
- R2: A store with req_be = 4'b1111 is written in the cycle it is accepted, and req_ready stays 1, so back-to-back full-word stores are accepted on consecutive cycles.
- R3: A store whose enables are neither 0 nor 4'b1111 replaces only the enabled lanes, where enable bit i covers data bits 8i+7:8i. All other stored bytes keep their value.
- R4: After a partial store is accepted, req_ready is 0 for exactly one cycle. A request presented in that cycle, whether a load or another partial store, is accepted one cycle later. Halfword stores take the same timing as byte stores.
- R5: A load accepted in cycle T gives rsp_valid = 1 in cycle T+1. In that cycle rsp_data is the whole corrected word and rsp_lanes is that word with the non-enabled bytes forced to 0.
- R6: The codeword is laid out as follows: bit 0 is overall parity, bits 1, 2, 4, 8, 16 and 32 are Hamming check bits, and the remaining bits 3 to 38 hold data in ascending order. req_flip is XORed into the codeword that the request writes. A single flipped bit, including the parity bit, is corrected on a load, and err_single is 1 only in the response cycle.
- R7: When the word read by a partial store holds a single-bit error, the corrected word is merged and a clean codeword is written back. err_single is 1 during the merge cycle.
- R8: A double-bit error sets err_double on a load. On a partial store it sets err_double during the merge cycle and cancels the write, so the stored codeword is unchanged.
- R9: A store with req_be = 0 is accepted without stalling and changes no stored data.
- R10: err_single and err_double are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte enables, bit i covers data bits 8i+7:8i |
| req_wdata | input | 32 | Store data |
| req_flip | input | 39 | Bits XORed into the codeword this request writes |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | 32 | Corrected full word |
| rsp_lanes | output | 32 | Corrected word with non-enabled lanes zeroed |
| err_single | output | 1 | Single-bit error corrected in this cycle |
| err_double | output | 1 | Uncorrectable error seen in this cycle |

## Verification
The bench builds the block with its default ADDR_W of 4, which gives sixteen words. That is enough to keep every scenario on its own address, so one word's injected errors cannot leak into another word's expected value. With this size, a single run covers consecutive full stores, stalled partial stores with a load or a second partial store queued behind them, and single and double errors on both the load path and the merge path.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int HAM_W   = 6;
    localparam int CODE_W  = DATA_W + HAM_W + 1;

    typedef enum logic {
        ST_IDLE,
        ST_MERGE
    } rmw_state_e;

    function automatic logic pos_is_check(input int pos);
        return (pos & (pos - 1)) == 0;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    always_comb begin
        logic [CODE_W-1:0] cw;
        int                d;
        logic              p;
        cw = '0;
        d  = 0;
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (!pos_is_check(pos)) begin
                cw[pos] = data_in[d];
                d++;
            end
        end
        for (int k = 0; k < HAM_W; k++) begin
            p = 1'b0;
            for (int pos = 1; pos < CODE_W; pos++) begin
                if (((pos >> k) & 1) == 1 && pos != (1 << k)) begin
                    p = p ^ cw[pos];
                end
            end
            cw[1 << k] = p;
        end
        cw[0]    = ^cw[CODE_W-1:1];
        code_out = cw;
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              single_err,
    output logic              double_err
);
    always_comb begin
        logic [HAM_W-1:0]  syn;
        logic              overall;
        logic [CODE_W-1:0] fixed;
        int                d;
        syn = '0;
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (code_in[pos]) begin
                syn = syn ^ HAM_W'(pos);
            end
        end
        overall    = ^code_in;
        fixed      = code_in;
        single_err = 1'b0;
        double_err = 1'b0;
        if (overall) begin
            if (int'(syn) < CODE_W) begin
                single_err = 1'b1;
                for (int pos = 0; pos < CODE_W; pos++) begin
                    if (HAM_W'(pos) == syn) begin
                        fixed[pos] = ~fixed[pos];
                    end
                end
            end else begin
                double_err = 1'b1;
            end
        end else if (syn != '0) begin
            double_err = 1'b1;
        end
        data_out = '0;
        d        = 0;
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (!pos_is_check(pos)) begin
                data_out[d] = fixed[pos];
                d++;
            end
        end
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = be[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
    end
endmodule

// File: rtl/code_array.sv
module code_array
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] wcode,
    output logic [CODE_W-1:0] rcode
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CODE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wcode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcode <= '0;
        end else if (re) begin
            rcode <= mem[addr];
        end
    end

    // R4: one port, so a read and a write never share a cycle
    p_single_port_r4: assert property (@(posedge clk) disable iff (!rst_n) !(we && re));
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    input  logic             rd_double,
    output logic             req_ready,
    output logic             accept,
    output logic             load_accept,
    output logic             mem_re,
    output logic             mem_we,
    output logic             in_merge
);
    rmw_state_e state, state_nx;
    logic       full_st, part_st;

    assign full_st = req_write && (req_be == '1);
    assign part_st = req_write && (req_be != '0) && (req_be != '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid && part_st) state_nx = ST_MERGE;
            ST_MERGE: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready   = 1'b0;
        in_merge    = 1'b0;
        accept      = 1'b0;
        load_accept = 1'b0;
        mem_re      = 1'b0;
        mem_we      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready   = 1'b1;
                accept      = req_valid;
                load_accept = req_valid && !req_write;
                mem_re      = req_valid && (!req_write || part_st);
                mem_we      = req_valid && full_st;
            end
            ST_MERGE: begin
                in_merge = 1'b1;
                mem_we   = !rd_double;
            end
        endcase
    end

    // R4: an accepted partial store stalls the next cycle
    p_partial_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && part_st) |=> !req_ready);
    // R4: the merge phase lasts one cycle
    p_merge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_merge |=> !in_merge);
endmodule

// File: rtl/ecc_word_mem.sv
module ecc_word_mem
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic [38:0]       req_flip,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic [31:0]       rsp_lanes,
    output logic              err_single,
    output logic              err_double
);
    logic              accept, load_accept, mem_re, mem_we, in_merge;
    logic              rsp_pend;
    logic [ADDR_W-1:0] h_addr, arr_addr;
    logic [LANES-1:0]  h_be;
    logic [DATA_W-1:0] h_wdata, dec_data, merged, enc_in;
    logic [CODE_W-1:0] h_flip, enc_out, wcode, rcode;
    logic              dec_single, dec_double;

    rmw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_be     (req_be),
        .rd_double  (dec_double),
        .req_ready  (req_ready),
        .accept     (accept),
        .load_accept(load_accept),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .in_merge   (in_merge)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_addr   <= '0;
            h_be     <= '0;
            h_wdata  <= '0;
            h_flip   <= '0;
            rsp_pend <= 1'b0;
        end else begin
            rsp_pend <= load_accept;
            if (accept) begin
                h_addr  <= req_addr;
                h_be    <= req_be;
                h_wdata <= req_wdata;
                h_flip  <= req_flip;
            end
        end
    end

    assign arr_addr = in_merge ? h_addr : req_addr;

    code_array #(.ADDR_W(ADDR_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .re   (mem_re),
        .addr (arr_addr),
        .wcode(wcode),
        .rcode(rcode)
    );

    ecc_decoder u_dec (
        .code_in   (rcode),
        .data_out  (dec_data),
        .single_err(dec_single),
        .double_err(dec_double)
    );

    lane_merge u_merge (
        .old_word(dec_data),
        .new_word(h_wdata),
        .be      (h_be),
        .merged  (merged)
    );

    assign enc_in = in_merge ? merged : req_wdata;

    ecc_encoder u_enc (
        .data_in (enc_in),
        .code_out(enc_out)
    );

    assign wcode      = enc_out ^ (in_merge ? h_flip : req_flip);
    assign rsp_valid  = rsp_pend;
    assign rsp_data   = dec_data;
    assign rsp_lanes  = dec_data & lane_mask(h_be);
    assign err_single = (rsp_pend || in_merge) && dec_single;
    assign err_double = (rsp_pend || in_merge) && dec_double;

    // R5: a load response follows acceptance by one cycle
    p_load_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_accept |=> rsp_valid);
    // R2: a full-word store writes in its accept cycle
    p_full_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && req_be == 4'hF) |-> mem_we);
    // R8: an uncorrectable read during the merge cancels the write
    p_abort_double_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_merge && err_double) |-> !mem_we);
    // R10: the two error flags exclude each other
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double));
endmodule

// File: tb/ecc_word_mem_bench.sv
module ecc_word_mem_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [38:0] req_flip = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data, rsp_lanes;
    logic        err_single, err_double;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc_cyc = 0;
    logic [31:0] model [16];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ecc_word_mem u_ecc_word_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_flip(req_flip), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_lanes(rsp_lanes), .err_single(err_single),
        .err_double(err_double)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic wr, input logic [3:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic [38:0] f, output int waits);
        waits = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
        req_wdata = d; req_flip = f;
        while (!req_ready) begin
            @(negedge clk);
            waits++;
        end
        @(posedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) model[a] = (model[a] & ~mask_of(be)) | (d & mask_of(be));
    endtask

    task automatic load_chk(input string req, input logic [3:0] a, input logic [3:0] be,
                            input logic [31:0] exp, input logic exp_s, input logic exp_d);
        int w;
        send(1'b0, a, be, 32'h0, '0, w);
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        if (!exp_d) begin
            check({req, " rsp_data"}, rsp_data, exp);
            check({req, " rsp_lanes"}, rsp_lanes, exp & mask_of(be));
        end
        check({req, " err_single"}, 32'(err_single), 32'(exp_s));
        check({req, " err_double"}, 32'(err_double), 32'(exp_d));
    endtask

    task automatic t_reset();
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 flags", {30'd0, err_single, err_double}, 32'd0);
    endtask

    task automatic t_full_stores();
        int w, c0;
        send(1'b1, 4'd0, 4'hF, 32'h11223344, '0, w);
        c0 = acc_cyc;
        check("R2 no wait", 32'(w), 32'd0);
        for (int i = 1; i < 4; i++) begin
            send(1'b1, 4'(i), 4'hF, 32'hA0B0C0D0 + 32'(i), '0, w);
            check("R2 consecutive accept", 32'(acc_cyc - c0), 32'(i));
        end
        load_chk("R5 word", 4'd0, 4'hF, 32'h11223344, 1'b0, 1'b0);
        load_chk("R5 halfword lanes", 4'd2, 4'b0011, model[2], 1'b0, 1'b0);
        load_chk("R5 byte lane", 4'd3, 4'b1000, model[3], 1'b0, 1'b0);
    endtask

    task automatic t_partial();
        int w;
        send(1'b1, 4'd1, 4'b0100, 32'h00EE0000, '0, w);
        check("R4 ready low in merge", 32'(req_ready), 32'd0);
        send(1'b0, 4'd1, 4'hF, 32'h0, '0, w);
        check("R4 load waits one cycle", 32'(w), 32'd1);
        check("R3 byte merge", rsp_data, 32'hA0EEC0D1);
        send(1'b1, 4'd2, 4'b1100, 32'h55660000, '0, w);
        send(1'b1, 4'd2, 4'b0001, 32'h00000077, '0, w);
        check("R4 second partial waits", 32'(w), 32'd1);
        @(negedge clk);
        check("R4 ready back after merge", 32'(req_ready), 32'd1);
        load_chk("R3 halfword merge", 4'd2, 4'hF, 32'h5566C077, 1'b0, 1'b0);
    endtask

    task automatic t_single();
        int w;
        send(1'b1, 4'd5, 4'hF, 32'hCAFEF00D, 39'(1) << 5, w);
        load_chk("R6 data bit fix", 4'd5, 4'hF, 32'hCAFEF00D, 1'b1, 1'b0);
        @(negedge clk);
        check("R6 flag one cycle", 32'(err_single), 32'd0);
        send(1'b1, 4'd9, 4'hF, 32'h01020304, 39'(1), w);
        load_chk("R6 parity bit fix", 4'd9, 4'hF, 32'h01020304, 1'b1, 1'b0);
        send(1'b1, 4'd6, 4'hF, 32'h89ABCDEF, 39'(1) << 12, w);
        send(1'b1, 4'd6, 4'b0001, 32'h00000042, '0, w);
        check("R7 single flag in merge", 32'(err_single), 32'd1);
        load_chk("R7 clean rewrite", 4'd6, 4'hF, 32'h89ABCD42, 1'b0, 1'b0);
    endtask

    task automatic t_double();
        int w;
        send(1'b1, 4'd7, 4'hF, 32'h13579BDF, (39'(1) << 3) | (39'(1) << 9), w);
        load_chk("R8 load double", 4'd7, 4'hF, 32'h0, 1'b0, 1'b1);
        send(1'b1, 4'd7, 4'b0010, 32'h0000FF00, '0, w);
        check("R8 double flag in merge", 32'(err_double), 32'd1);
        check("R10 exclusive", 32'(err_single), 32'd0);
        load_chk("R8 array unchanged", 4'd7, 4'hF, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_empty();
        int w;
        send(1'b1, 4'd0, 4'h0, 32'hFFFFFFFF, '0, w);
        check("R9 no stall", 32'(req_ready), 32'd1);
        load_chk("R9 data kept", 4'd0, 4'hF, 32'h11223344, 1'b0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_stores();
        t_partial();
        t_single();
        t_double();
        t_empty();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule